// File: doc/BRIEF.md
# SerDes Comma Lock Monitor

This block watches the 18-bit parallel output of an 8b10b deserializer that gives no lock indication of its own. Each received word carries a 16-bit payload and two K-character flags, one for each byte. The deserializer recognises a comma of only one disparity and always places it in the low byte. Alignment is therefore judged from a single sync word: a comma in the low byte and a fixed data symbol in the high byte.

The monitor has two states, hunting and locked. While hunting, it counts sync words and declares lock once it has seen enough of them with no misaligned K flag in between. While locked, it keeps an up/down error level. Bad words raise the level and good words lower it, so short error bursts are absorbed. Lock is dropped only when the level reaches a programmable limit. Each loss gives a one-cycle pulse and advances a saturating event count.

Top module: `comma_lock_monitor`

## Requirements
- R1: While `rst` is high at a rising clock edge, `locked`, `lock_lost`, `err_count` and `loss_count` become 0 and the sync run restarts.
- R2: A sync word is one with `rx_k_lo`=1, `rx_data[7:0]`=0xBC, `rx_k_hi`=0 and `rx_data[15:8]`=0xC5. While hunting, `locked` rises at the edge that samples the LOCK_RUN-th counted sync word.
- R3: While hunting, a word with both K flags 0, or a low-byte comma (0xBC, `rx_k_lo`=1, `rx_k_hi`=0) whose high byte is not 0xC5, neither advances nor clears the sync run.
- R4: A bad word is one with `rx_k_hi`=1, or with `rx_k_lo`=1 and a low byte other than 0xBC. While hunting, a bad word clears the sync run, so LOCK_RUN further sync words are needed.
- R5: While locked, a bad word adds 1 to `err_count` and any other word subtracts 1 from it, never going below 0. While hunting, `err_count` is 0.
- R6: While `err_count` stays below ERR_LIMIT, `locked` stays 1, so a burst of ERR_LIMIT-1 bad words does not lose lock.
- R7: The bad word that would bring `err_count` to ERR_LIMIT clears `locked` and `err_count` and raises `lock_lost` for exactly one cycle. The block then hunts again from an empty run.
- R8: `loss_count` adds 1 on each loss of lock and holds at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 16 | Received payload; the low byte holds the comma |
| rx_k_hi | input | 1 | K-character flag for the high byte |
| rx_k_lo | input | 1 | K-character flag for the low byte |
| locked | output | 1 | Word alignment is judged good |
| lock_lost | output | 1 | One-cycle pulse when lock drops |
| err_count | output | $clog2(ERR_LIMIT+1) | Current error level while locked |
| loss_count | output | CNT_W | Saturating number of lock losses |

## Verification
The bench builds the monitor with LOCK_RUN=3, ERR_LIMIT=5 and CNT_W=3. With these values a full lock, a burst that stops one word short of the limit, and an actual loss each take only a few words. The 3-bit loss counter reaches its ceiling of 7 after a handful of lock and loss rounds, so saturation is exercised within a short run. The same small limits let the table run the error level up and down to its floor of zero, and across the exact threshold, in under thirty words.

// File: rtl/comma_lock_monitor.sv
module comma_lock_monitor #(
  parameter int LOCK_RUN  = 4,
  parameter int ERR_LIMIT = 256,
  parameter int CNT_W     = 16,
  localparam int ERR_W    = $clog2(ERR_LIMIT + 1),
  localparam int RUN_W    = $clog2(LOCK_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      rx_data,
  input  logic             rx_k_hi,
  input  logic             rx_k_lo,
  output logic             locked,
  output logic             lock_lost,
  output logic [ERR_W-1:0] err_count,
  output logic [CNT_W-1:0] loss_count
);
  localparam logic [7:0] COMMA = 8'hBC;
  localparam logic [7:0] MARK  = 8'hC5;

  logic [RUN_W-1:0] run;

  wire comma_lo  = rx_k_lo && (rx_data[7:0] == COMMA);
  wire sync_word = comma_lo && !rx_k_hi && (rx_data[15:8] == MARK);
  wire bad_word  = rx_k_hi || (rx_k_lo && !comma_lo);
  wire run_done  = sync_word && (run == RUN_W'(LOCK_RUN - 1));
  wire err_full  = bad_word && (err_count == ERR_W'(ERR_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= '0;
      locked     <= 1'b0;
      lock_lost  <= 1'b0;
      err_count  <= '0;
      loss_count <= '0;
    end else begin
      lock_lost <= 1'b0;
      if (!locked) begin
        if (bad_word)       run <= '0;
        else if (run_done) begin
          run    <= '0;
          locked <= 1'b1;
        end
        else if (sync_word) run <= run + RUN_W'(1);
      end else if (err_full) begin
        locked    <= 1'b0;
        lock_lost <= 1'b1;
        err_count <= '0;
        if (loss_count != '1) loss_count <= loss_count + CNT_W'(1);
      end else if (bad_word) begin
        err_count <= err_count + ERR_W'(1);
      end else if (err_count != '0) begin
        err_count <= err_count - ERR_W'(1);
      end
    end
  end

  assert_err_below_limit_R6: assert property (@(posedge clk) disable iff (rst)
    err_count < ERR_W'(ERR_LIMIT));
  assert_err_idle_hunting_R5: assert property (@(posedge clk) disable iff (rst)
    !locked |-> err_count == '0);
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    lock_lost |=> !lock_lost);
  assert_pulse_on_drop_R7: assert property (@(posedge clk) disable iff (rst)
    lock_lost |-> (!locked && $past(locked)));
  assert_loss_saturates_R8: assert property (@(posedge clk) disable iff (rst)
    (loss_count == '1) |=> (loss_count == '1));
endmodule

// File: tb/comma_lock_monitor_bench.sv
module comma_lock_monitor_bench;
  localparam int LR = 3, EL = 5, CW = 3;
  localparam int EW = $clog2(EL + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] rx_data = '0;
  logic rx_k_hi = 1'b0, rx_k_lo = 1'b0;
  logic locked, lock_lost;
  logic [EW-1:0] err_count;
  logic [CW-1:0] loss_count;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  comma_lock_monitor #(.LOCK_RUN(LR), .ERR_LIMIT(EL), .CNT_W(CW)) u_comma_lock_monitor (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_k_hi(rx_k_hi), .rx_k_lo(rx_k_lo),
    .locked(locked), .lock_lost(lock_lost), .err_count(err_count), .loss_count(loss_count));

  // vector: req[30:27] data[26:11] khi[10] klo[9] lock[8] lost[7] err[6:3] loss[2:0]
  function automatic logic [30:0] v(int req, logic [15:0] d, logic kh, logic kl,
                                    logic lk, logic ls, int er, int lc);
    return {4'(req), d, kh, kl, lk, ls, 4'(er), 3'(lc)};
  endfunction

  localparam int N = 21;
  localparam logic [30:0] VEC [N] = '{
    v(2, 16'hC5BC, 0, 1, 0, 0, 0, 0),  // R2 sync, run 1
    v(3, 16'h1234, 0, 0, 0, 0, 0, 0),  // R3 plain word holds run
    v(3, 16'h11BC, 0, 1, 0, 0, 0, 0),  // R3 comma, wrong high byte holds run
    v(2, 16'hC5BC, 0, 1, 0, 0, 0, 0),  // R2 run 2
    v(4, 16'h00F7, 0, 1, 0, 0, 0, 0),  // R4 misaligned K clears run
    v(4, 16'hC5BC, 0, 1, 0, 0, 0, 0),  // R4 run 1
    v(4, 16'hC5BC, 0, 1, 0, 0, 0, 0),  // R4 run 2
    v(2, 16'hC5BC, 0, 1, 1, 0, 0, 0),  // R2 third sync locks
    v(5, 16'h0000, 1, 0, 1, 0, 1, 0),  // R5 high K counts up
    v(5, 16'h0000, 1, 0, 1, 0, 2, 0),  // R5
    v(5, 16'hC5BC, 0, 1, 1, 0, 1, 0),  // R5 good word counts down
    v(5, 16'h1234, 0, 0, 1, 0, 0, 0),  // R5
    v(5, 16'h1234, 0, 0, 1, 0, 0, 0),  // R5 floor at zero
    v(6, 16'h0000, 1, 0, 1, 0, 1, 0),  // R6 burst
    v(6, 16'h0000, 1, 0, 1, 0, 2, 0),  // R6
    v(6, 16'h0000, 1, 0, 1, 0, 3, 0),  // R6
    v(6, 16'h0000, 1, 0, 1, 0, 4, 0),  // R6 limit-1 still locked
    v(7, 16'h0000, 1, 0, 0, 1, 0, 1),  // R7 loss with pulse
    v(7, 16'hC5BC, 0, 1, 0, 0, 0, 1),  // R7 pulse gone, hunting
    v(7, 16'hC5BC, 0, 1, 0, 0, 0, 1),  // R7 not yet locked
    v(7, 16'hC5BC, 0, 1, 1, 0, 0, 1)   // R7 full run relocks
  };

  task automatic step(logic [15:0] d, logic kh, logic kl);
    @(negedge clk);
    rx_data = d; rx_k_hi = kh; rx_k_lo = kl;
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic lk, logic ls, int er, int lc);
    tests++;
    if (locked !== lk || lock_lost !== ls || int'(err_count) != er || int'(loss_count) != lc) begin
      fails++;
      $display("FAIL %s: got lock=%0b lost=%0b err=%0d loss=%0d, expected lock=%0b lost=%0b err=%0d loss=%0d",
               req, locked, lock_lost, err_count, loss_count, lk, ls, er, lc);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1", 0, 0, 0, 0);  // R1 reset state
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      step(VEC[i][26:11], VEC[i][10], VEC[i][9]);
      check($sformatf("R%0d vec%0d", VEC[i][30:27], i),
            VEC[i][8], VEC[i][7], int'(VEC[i][6:3]), int'(VEC[i][2:0]));
    end

    // R8: repeat lock/loss rounds until the 3-bit count tops out
    for (int r = 0; r < 7; r++) begin
      for (int b = 0; b < EL; b++) step(16'h0000, 1, 0);
      for (int s = 0; s < LR; s++) step(16'hC5BC, 0, 1);
    end
    check("R8 saturated, relocked", 1, 0, 0, 7);
    for (int b = 0; b < EL; b++) step(16'h0000, 1, 0);
    check("R8 hold at max", 0, 1, 0, 7);

    // R1: reset while locked, then a fresh full run is needed
    for (int s = 0; s < LR; s++) step(16'hC5BC, 0, 1);
    step(16'h0000, 1, 0);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R1 mid-run reset", 0, 0, 0, 0);
    @(negedge clk) rst = 1'b0;
    step(16'hC5BC, 0, 1);
    step(16'hC5BC, 0, 1);
    check("R1 run restarted", 0, 0, 0, 0);
    step(16'hC5BC, 0, 1);
    check("R2 lock after reset", 1, 0, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule